// File: doc/BRIEF.md
# Two-Three Exponent Term Product Multiplier

This block multiplies two operands held in a two-base exponent form: each operand is a sum of up to five terms 2^i·3^j, each term carried as a pair of small exponents (i, j) with an enable bit. The product of two such sums is the sum of every cross product of their terms. Each cross product is itself a single two-base term. Its exponents are the sums of the binary exponents and of the ternary exponents, so no multiplier is needed. The power of three comes from a small table. A left shift by the summed binary exponent then gives the binary value of the term.

All 25 cross terms are formed in parallel and captured in one register stage. A registered binary adder tree of five levels then adds them up, so one new operand pair can be accepted on every clock. The result leaves as an ordinary binary number with a valid flag, six cycles after the input strobe. Conversion of binary values into the exponent form happens elsewhere.

Top module: `twothree_term_mult`

## Requirements
- R1: Six rising edges after the edge that samples `in_valid` high, `product` equals (A·B) mod 2^16, where A = Σ over enabled slots of 2^i·3^j of operand A, and B likewise. Slot k occupies bits [2k+1:2k] of each exponent bus and bit k of the enable bus.
- R2: `out_valid` is high on exactly the cycles that follow, by six edges, an edge that sampled `in_valid` high; it is low on every other cycle.
- R3: A slot whose enable bit is 0 contributes nothing, whatever its exponent bits hold.
- R4: If no slot of either operand is enabled, the result is 0.
- R5: While `rst_n` is low, `out_valid` and `product` are 0.
- R6: Operands strobed on consecutive cycles each give exactly one result, in order, one per cycle.
- R7: The largest single cross term, 2^6·3^6 = 46656, and the product 255·255 = 65025 are delivered exactly.
- R8: While `out_valid` is low, `product` keeps the last delivered value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| a_bexp | input | 10 | Operand A binary exponents, 2 bits per slot |
| a_texp | input | 10 | Operand A ternary exponents, 2 bits per slot |
| a_en | input | 5 | Operand A slot enables |
| b_bexp | input | 10 | Operand B binary exponents, 2 bits per slot |
| b_texp | input | 10 | Operand B ternary exponents, 2 bits per slot |
| b_en | input | 5 | Operand B slot enables |
| out_valid | output | 1 | Result strobe |
| product | output | 16 | Binary product |

## Verification
A wrong power-of-three table entry or shift amount corrupts only the products that use that exponent sum. Directed operands place single terms on each corner so that such a fault shows on the very result six cycles later. A lost or doubled term in the adder tree gives a wrong sum on nearly every random result. A valid bit out of step with its data shows as a result on the wrong cycle, as a stale value, or as a queue of expected results that does not drain. Disabled slots are loaded with maximal exponents, so a leak of one of them inflates the product by at least one.

// File: rtl/twothree_mult_pkg.sv
package twothree_mult_pkg;

   // Integer power of three, evaluated at elaboration.
   function automatic longint pow3(input int e);
      longint r;
      r = 1;
      for (int k = 0; k < e; k++) r = r * 3;
      return r;
   endfunction

   // Number of nodes left after l halving levels of an n-leaf tree.
   function automatic int lvl_cnt(input int n, input int l);
      int c;
      c = n;
      for (int k = 0; k < l; k++) c = (c + 1) / 2;
      return c;
   endfunction

   // Bits needed to hold value v.
   function automatic int bits_for(input longint v);
      int b;
      b = 0;
      while ((longint'(1) << b) <= v) b++;
      return b;
   endfunction

endpackage

// File: rtl/pair_term.sv
module pair_term
   import twothree_mult_pkg::*;
#(
   parameter int EXP_W = 2,
   parameter int TBL_W = 12,
   parameter int ACC_W = 16
)(
   input  logic [EXP_W-1:0] a_b,
   input  logic [EXP_W-1:0] a_t,
   input  logic [EXP_W-1:0] b_b,
   input  logic [EXP_W-1:0] b_t,
   input  logic             en,
   output logic [ACC_W-1:0] term
);
   localparam int SUM_W = EXP_W + 1;
   localparam int TBL_D = 1 << SUM_W;

   logic [SUM_W-1:0] bsum;
   logic [SUM_W-1:0] tsum;
   logic [TBL_W-1:0] p3_tbl [TBL_D];

   // Power-of-three table, one entry per possible exponent sum.
   for (genvar e = 0; e < TBL_D; e++) begin : g_tbl
      localparam longint P = pow3(e);
      assign p3_tbl[e] = TBL_W'(P);
   end

   assign bsum = SUM_W'(a_b) + SUM_W'(b_b);
   assign tsum = SUM_W'(a_t) + SUM_W'(b_t);

   always_comb begin
      if (en) term = ACC_W'(p3_tbl[tsum]) << bsum;
      else    term = '0;
   end
endmodule

// File: rtl/term_sum_tree.sv
module term_sum_tree
   import twothree_mult_pkg::*;
#(
   parameter int N_LEAF = 25,
   parameter int ACC_W  = 16
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             leaf_v,
   input  logic [ACC_W-1:0] leaf [N_LEAF],
   output logic             sum_v,
   output logic [ACC_W-1:0] sum
);
   localparam int DEPTH = $clog2(N_LEAF);

   if (N_LEAF < 2) begin : g_bad_leaf
      $error("term_sum_tree needs at least two leaves");
   end

   for (genvar lv = 0; lv < DEPTH; lv++) begin : g_lvl
      localparam int NI = lvl_cnt(N_LEAF, lv);
      localparam int NO = lvl_cnt(N_LEAF, lv + 1);

      logic [ACC_W-1:0] d [NI];
      logic             dv;
      logic [ACC_W-1:0] q [NO];
      logic             v;

      if (lv == 0) begin : g_src
         assign d  = leaf;
         assign dv = leaf_v;
      end else begin : g_src
         assign d  = g_lvl[lv-1].q;
         assign dv = g_lvl[lv-1].v;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) v <= 1'b0;
         else        v <= dv;
      end

      for (genvar k = 0; k < NO; k++) begin : g_node
         if (2 * k + 1 < NI) begin : g_add
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)  q[k] <= '0;
               else if (dv) q[k] <= d[2*k] + d[2*k+1];
            end
         end else begin : g_pass
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)  q[k] <= '0;
               else if (dv) q[k] <= d[2*k];
            end
         end
      end
   end

   assign sum   = g_lvl[DEPTH-1].q[0];
   assign sum_v = g_lvl[DEPTH-1].v;
endmodule

// File: rtl/twothree_term_mult.sv
module twothree_term_mult
   import twothree_mult_pkg::*;
#(
   parameter int TERMS = 5,
   parameter int EXP_W = 2,
   parameter int TBL_W = 12,
   parameter int ACC_W = 16
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [TERMS*EXP_W-1:0] a_bexp,
   input  logic [TERMS*EXP_W-1:0] a_texp,
   input  logic [TERMS-1:0]       a_en,
   input  logic [TERMS*EXP_W-1:0] b_bexp,
   input  logic [TERMS*EXP_W-1:0] b_texp,
   input  logic [TERMS-1:0]       b_en,
   output logic                   out_valid,
   output logic [ACC_W-1:0]       product
);
   localparam int  N_LEAF  = TERMS * TERMS;
   localparam int  EXP_MAX = (1 << EXP_W) - 1;
   localparam longint P3_TOP = pow3(2 * EXP_MAX);

   if (TBL_W < bits_for(P3_TOP)) begin : g_bad_tbl
      $error("TBL_W too narrow for the largest power of three");
   end
   if (ACC_W < TBL_W) begin : g_bad_acc
      $error("ACC_W must be at least TBL_W");
   end
   if (TERMS < 2) begin : g_bad_terms
      $error("TERMS must be at least 2");
   end

   logic [ACC_W-1:0] term_c [N_LEAF];
   logic [ACC_W-1:0] term_q [N_LEAF];
   logic             term_v;

   for (genvar p = 0; p < TERMS; p++) begin : g_a
      for (genvar q = 0; q < TERMS; q++) begin : g_b
         pair_term #(
            .EXP_W (EXP_W),
            .TBL_W (TBL_W),
            .ACC_W (ACC_W)
         ) u_term (
            .a_b  (a_bexp[p*EXP_W +: EXP_W]),
            .a_t  (a_texp[p*EXP_W +: EXP_W]),
            .b_b  (b_bexp[q*EXP_W +: EXP_W]),
            .b_t  (b_texp[q*EXP_W +: EXP_W]),
            .en   (a_en[p] & b_en[q]),
            .term (term_c[p*TERMS+q])
         );

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        term_q[p*TERMS+q] <= '0;
            else if (in_valid) term_q[p*TERMS+q] <= term_c[p*TERMS+q];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) term_v <= 1'b0;
      else        term_v <= in_valid;
   end

   term_sum_tree #(
      .N_LEAF (N_LEAF),
      .ACC_W  (ACC_W)
   ) u_tree (
      .clk    (clk),
      .rst_n  (rst_n),
      .leaf_v (term_v),
      .leaf   (term_q),
      .sum_v  (out_valid),
      .sum    (product)
   );
endmodule

// File: rtl/twothree_term_mult_chk.sv
module twothree_term_mult_chk #(
   parameter int TERMS = 5,
   parameter int EXP_W = 2,
   parameter int TBL_W = 12,
   parameter int ACC_W = 16
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [TERMS*EXP_W-1:0] a_bexp,
   input  logic [TERMS*EXP_W-1:0] a_texp,
   input  logic [TERMS-1:0]       a_en,
   input  logic [TERMS*EXP_W-1:0] b_bexp,
   input  logic [TERMS*EXP_W-1:0] b_texp,
   input  logic [TERMS-1:0]       b_en,
   input  logic                   out_valid,
   input  logic [ACC_W-1:0]       product
);
   localparam int LAT = 1 + $clog2(TERMS * TERMS);

   function automatic longint op_val(input logic [TERMS*EXP_W-1:0] be,
                                     input logic [TERMS*EXP_W-1:0] te,
                                     input logic [TERMS-1:0] en);
      longint s;
      longint t;
      s = 0;
      for (int k = 0; k < TERMS; k++) begin
         if (en[k]) begin
            t = longint'(1) << be[k*EXP_W +: EXP_W];
            for (int m = 0; m < int'(te[k*EXP_W +: EXP_W]); m++) t = t * 3;
            s = s + t;
         end
      end
      return s;
   endfunction

   logic [ACC_W-1:0] exp_now;
   logic [ACC_W-1:0] exp_pipe [LAT];
   logic [LAT-1:0]   v_pipe;
   logic [LAT-1:0]   z_pipe;

   always_comb exp_now = ACC_W'(op_val(a_bexp, a_texp, a_en) *
                                op_val(b_bexp, b_texp, b_en));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_pipe <= '0;
         z_pipe <= '0;
         for (int k = 0; k < LAT; k++) exp_pipe[k] <= '0;
      end else begin
         v_pipe <= {v_pipe[LAT-2:0], in_valid};
         z_pipe <= {z_pipe[LAT-2:0], (a_en == '0) || (b_en == '0)};
         exp_pipe[0] <= exp_now;
         for (int k = 1; k < LAT; k++) exp_pipe[k] <= exp_pipe[k-1];
      end
   end

   assert_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> product == exp_pipe[LAT-1]);

   assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == v_pipe[LAT-1]);

   assert_empty_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && z_pipe[LAT-1]) |-> product == '0);

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(product));
endmodule

bind twothree_term_mult twothree_term_mult_chk #(
   .TERMS (TERMS),
   .EXP_W (EXP_W),
   .TBL_W (TBL_W),
   .ACC_W (ACC_W)
) u_chk (.*);

// File: tb/twothree_term_mult_bench.sv
module twothree_term_mult_bench;
   localparam int TERMS = 5;
   localparam int EXP_W = 2;
   localparam int ACC_W = 16;
   localparam int VW    = TERMS * EXP_W;

   logic             clk;
   logic             rst_n;
   logic             in_valid;
   logic [VW-1:0]    a_bexp, a_texp, b_bexp, b_texp;
   logic [TERMS-1:0] a_en, b_en;
   logic             out_valid;
   logic [ACC_W-1:0] product;

   int n_chk  = 0;
   int n_fail = 0;
   logic [ACC_W-1:0] exp_q [$];
   string            tag_q [$];
   logic [ACC_W-1:0] last_prod = '0;
   int unsigned      seed = 32'd2024;

   twothree_term_mult u_twothree_term_mult (.*);

   initial clk = 1'b0;
   always #4 clk = ~clk;

   task automatic check(input bit ok, input string tag,
                        input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   function automatic longint op_val(input logic [VW-1:0] be,
                                     input logic [VW-1:0] te,
                                     input logic [TERMS-1:0] en);
      longint s = 0;
      for (int k = 0; k < TERMS; k++)
         if (en[k]) s += (longint'(1) << be[k*EXP_W +: EXP_W]) * (3 ** te[k*EXP_W +: EXP_W]);
      return s;
   endfunction

   task automatic send(input logic [VW-1:0] ab, input logic [VW-1:0] at,
                       input logic [TERMS-1:0] ae,
                       input logic [VW-1:0] bb, input logic [VW-1:0] bt,
                       input logic [TERMS-1:0] be, input string tag);
      @(negedge clk);
      in_valid = 1'b1;
      a_bexp = ab; a_texp = at; a_en = ae;
      b_bexp = bb; b_texp = bt; b_en = be;
      exp_q.push_back(ACC_W'(op_val(ab, at, ae) * op_val(bb, bt, be)));
      tag_q.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   // Result monitor: compares every delivered result in order.
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R2 unexpected result", product, 0);
         end else begin
            logic [ACC_W-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(product == e, t, product, e);
         end
         last_prod = product;
      end
   end

   initial begin
      #1600000;
      check(1'b0, "watchdog", 0, 1);
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(seed));
      rst_n = 1'b0; in_valid = 1'b0;
      a_bexp = '0; a_texp = '0; a_en = '0;
      b_bexp = '0; b_texp = '0; b_en = '0;
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R5 out_valid in reset", out_valid, 0);
      check(product == '0, "R5 product in reset", product, 0);
      rst_n = 1'b1;

      // R2: latency from strobe to result strobe.
      begin
         int cnt = 0;
         send('0, '0, 5'b00001, '0, '0, 5'b00001, "R1 one times one");
         idle(1);
         cnt = 1;
         while (!out_valid && cnt < 20) begin
            @(negedge clk);
            cnt++;
         end
         check(cnt == 6, "R2 latency", cnt, 6);
      end
      idle(4);

      // R7: largest single term, slot 4 of each operand = (3,3).
      send(10'b11_00_00_00_00, 10'b11_00_00_00_00, 5'b10000,
           10'b11_00_00_00_00, 10'b11_00_00_00_00, 5'b10000, "R7 term 46656");
      // R7: 255 = 216 + 27 + 12 -> (3,3),(0,3),(2,1).
      send(10'b00_00_10_00_11, 10'b00_00_01_11_11, 5'b00111,
           10'b00_00_10_00_11, 10'b00_00_01_11_11, 5'b00111, "R7 255x255");
      // R3: only slot 0 enabled, disabled slots hold (3,3); 2 x 3 = 6.
      send(10'b11_11_11_11_01, 10'b11_11_11_11_00, 5'b00001,
           10'b11_11_11_11_00, 10'b11_11_11_11_01, 5'b00001, "R3 disabled slots");
      // R4: operand A empty.
      send(10'h3FF, 10'h3FF, 5'b00000, 10'h3FF, 10'h3FF, 5'b11111, "R4 empty A");
      // R4: operand B empty.
      send(10'h3FF, 10'h3FF, 5'b11111, 10'h155, 10'h2AA, 5'b00000, "R4 empty B");
      // R1: full exponents wrap modulo 2^16.
      send(10'h3FF, 10'h3FF, 5'b11111, 10'h3FF, 10'h3FF, 5'b11111, "R1 wrap");
      idle(10);
      check(exp_q.size() == 0, "R6 directed drained", exp_q.size(), 0);

      // R8: output held while idle.
      begin
         logic [ACC_W-1:0] held;
         held = last_prod;
         idle(3);
         check(out_valid == 1'b0, "R2 idle no strobe", out_valid, 0);
         check(product == held, "R8 product held", product, held);
      end

      // R6 / R1: back-to-back random operands.
      for (int n = 0; n < 60; n++) begin
         send(VW'($urandom), VW'($urandom), TERMS'($urandom),
              VW'($urandom), VW'($urandom), TERMS'($urandom), "R6 R1 random stream");
      end
      // R1: random with gaps.
      for (int n = 0; n < 40; n++) begin
         send(VW'($urandom), VW'($urandom), TERMS'($urandom),
              VW'($urandom), VW'($urandom), TERMS'($urandom), "R1 random gapped");
         idle(($urandom % 3) + 1);
      end
      idle(12);
      check(exp_q.size() == 0, "R6 one result per strobe", exp_q.size(), 0);

      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule